// File: doc/BRIEF.md
# Wide-to-Serial Pixel Port Multiplexer

This block takes a wide pixel word carrying eight pixel slots per colour channel, 8 bits each for red, green and blue, plus five video control bits. It turns the word into a stream of one pixel per cycle on a fast pixel clock. The slow load clock is eight times slower than the pixel clock. The block produces it itself as `load_out`, a divide-by-eight of the pixel clock. Upstream logic presents a new word once per `load_out` period. The block samples that word on the pixel-clock edge where `load_out` falls, moves it into a holding register, and then sends its eight slots out in fixed order with a fixed latency.

A divider control input, `div_run`, holds the phase counter in reset while it is 0. The 0-to-1 transition realigns the sequence so that the first complete word after release starts again at slot A. While the divider is held, the outputs are forced to zero and any words already in the pipeline are discarded. The colour and control inputs are treated as synchronous to the pixel clock.

Top module: `pixport_serializer`

## Requirements
- R1: While `rst` is high, and in the cycle after a reset edge, all pixel, control and `pix_first` outputs are 0 and `load_out` is 0.
- R2: A clock edge that samples `div_run` = 0 clears the pipeline. After that edge, every pixel, control and `pix_first` output is 0 and `load_out` is 0, and words captured earlier are never emitted.
- R3: Slot k of a channel occupies bits [8k+7:8k] of that channel's input bus. The slots of one word leave in the order k = 0 to 7, on eight consecutive cycles.
- R4: Slot 0 of a word appears at the outputs SLOTS/2 + OUT_STAGES - 1 cycles after the edge that captured the word (5 with default parameters). `pix_first` is 1 exactly when slot 0 is on the outputs. After a release, slot 0 of the first word appears after the 10th rising edge, counting the first edge that samples `div_run` = 1 as the 1st.
- R5: On the first edge that samples `div_run` = 1, `load_out` rises. From then on it is high for 4 cycles and low for 4 cycles, with a period of 8 cycles.
- R6: Input words and control bits are sampled only on the edge at which `load_out` falls, which is the 4th edge after it rises. Input values at all other edges have no effect on the outputs.
- R7: The five control outputs carry the control bits captured with a word for all eight of its pixels. They are 0 when no captured word is being emitted.
- R8: For a word captured with blank = 1, all colour outputs are 0 for its eight pixels, while hsync, vsync, csync and field still pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| div_run | input | 1 | 0 holds the phase divider in reset; a rise releases it |
| px_red_in | input | 64 | Red slots A..H, slot k at bits [8k+7:8k] |
| px_grn_in | input | 64 | Green slots A..H |
| px_blu_in | input | 64 | Blue slots A..H |
| blank_in | input | 1 | Blanking flag for the word |
| hsync_in | input | 1 | Horizontal sync for the word |
| vsync_in | input | 1 | Vertical sync for the word |
| csync_in | input | 1 | Composite sync for the word |
| field_in | input | 1 | Odd/even field flag for the word |
| load_out | output | 1 | Pixel clock divided by 8 |
| pix_red | output | 8 | Red pixel out |
| pix_grn | output | 8 | Green pixel out |
| pix_blu | output | 8 | Blue pixel out |
| pix_first | output | 1 | High while slot A is on the outputs |
| blank_out | output | 1 | Blank flag travelling with the pixel |
| hsync_out | output | 1 | Horizontal sync travelling with the pixel |
| vsync_out | output | 1 | Vertical sync travelling with the pixel |
| csync_out | output | 1 | Composite sync travelling with the pixel |
| field_out | output | 1 | Field flag travelling with the pixel |

## Verification
Several properties are checked on every cycle. These are the wrap-around step of the phase counter, its parking while the divider is held, and the alignment of the `load_out` rise to phase 0. They also cover the rule that the holding register changes only at the last phase, the marking of slot A at phase 0, and zero colour on blanked pixels. The fixed latency after each release, the slot ordering, and the fact that inputs between capture edges are ignored all depend on whole words. Those can only be shown by the bench's scenarios: it drives scrambled inputs on every cycle, stops the divider at varied phases, and compares every output against its own schedule of expected pixels.

// File: rtl/pxm_pkg.sv
package pxm_pkg;

    localparam int SLOTS  = 8;
    localparam int BPC    = 8;
    localparam int PH_W   = $clog2(SLOTS);
    localparam int CAP_PH = SLOTS / 2 - 1;

    typedef logic [PH_W-1:0] phase_t;

    typedef struct packed {
        logic blank;
        logic hsync;
        logic vsync;
        logic csync;
        logic field;
    } vctl_t;

    typedef struct packed {
        logic [BPC-1:0] r;
        logic [BPC-1:0] g;
        logic [BPC-1:0] b;
    } pix_t;

    typedef struct packed {
        logic                  vld;
        vctl_t                 ctl;
        pix_t [SLOTS-1:0]      slot;
    } word_t;

    typedef struct packed {
        logic  first;
        vctl_t ctl;
        pix_t  px;
    } emit_t;

    function automatic logic lo_level(phase_t p);
        return p < phase_t'(SLOTS / 2);
    endfunction

    function automatic phase_t step(phase_t p);
        return phase_t'(p + phase_t'(1));
    endfunction

endpackage

// File: rtl/pxm_phase_gen.sv
module pxm_phase_gen
    import pxm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    output phase_t phase_q,
    output phase_t phase_nxt,
    output logic   load_out
);

    logic lo_q;

    assign phase_nxt = run ? step(phase_q) : phase_t'(SLOTS - 1);
    assign load_out  = lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= phase_t'(SLOTS - 1);
            lo_q    <= 1'b0;
        end else begin
            phase_q <= phase_nxt;
            lo_q    <= run && lo_level(phase_nxt);
        end
    end

    // R3: running counter advances by one, wrapping
    assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
        run |=> phase_q == step($past(phase_q)));

    // R2: held divider parks the phase and silences load_out
    assert_held_park_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase_q == phase_t'(SLOTS - 1)) && !load_out);

    // R5: load_out rises only at phase 0
    assert_lo_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(load_out) |-> phase_q == '0);

endmodule

// File: rtl/pxm_capture.sv
module pxm_capture
    import pxm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run,
    input  phase_t                 phase_q,
    input  logic [SLOTS*BPC-1:0]   red_in,
    input  logic [SLOTS*BPC-1:0]   grn_in,
    input  logic [SLOTS*BPC-1:0]   blu_in,
    input  vctl_t                  ctl_in,
    output word_t                  hold_q
);

    word_t raw;
    word_t cap_q;

    assign raw.vld = 1'b1;
    assign raw.ctl = ctl_in;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign raw.slot[k].r = red_in[k*BPC +: BPC];
        assign raw.slot[k].g = grn_in[k*BPC +: BPC];
        assign raw.slot[k].b = blu_in[k*BPC +: BPC];
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cap_q  <= '0;
            hold_q <= '0;
        end else begin
            if (phase_q == phase_t'(CAP_PH))
                cap_q <= raw;
            if (phase_q == phase_t'(SLOTS - 2))
                hold_q <= cap_q;
        end
    end

    // R6: the holding word only changes at the end of a frame
    assert_hold_frame_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !$past(rst) && !$stable(hold_q)) |-> phase_q == phase_t'(SLOTS - 1));

endmodule

// File: rtl/pxm_emit.sv
module pxm_emit
    import pxm_pkg::*;
#(
    parameter int OUT_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  phase_t phase_q,
    input  phase_t phase_nxt,
    input  word_t  hold_q,
    output emit_t  out
);

    emit_t d0;
    emit_t pipe [OUT_STAGES];
    pix_t  sel;

    assign sel = hold_q.slot[phase_nxt];

    always_comb begin
        d0.first = hold_q.vld && (phase_nxt == '0);
        d0.ctl   = hold_q.vld ? hold_q.ctl : '0;
        d0.px    = (hold_q.vld && !hold_q.ctl.blank) ? sel : '0;
    end

    for (genvar s = 0; s < OUT_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || !run) pipe[0] <= '0;
                else             pipe[0] <= d0;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst || !run) pipe[s] <= '0;
                else             pipe[s] <= pipe[s-1];
            end
        end
    end

    assign out = pipe[OUT_STAGES-1];

    // R4: slot A leaves the mux while the counter sits at phase 0
    assert_first_phase_R4: assert property (@(posedge clk) disable iff (rst)
        pipe[0].first |-> phase_q == '0);

    // R8: blanked pixels carry no colour
    assert_blank_zero_R8: assert property (@(posedge clk) disable iff (rst)
        out.ctl.blank |-> out.px == '0);

    // R2: a held divider empties the output path
    assert_held_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pipe[0] == '0) && (out == '0));

endmodule

// File: rtl/pixport_serializer.sv
module pixport_serializer
    import pxm_pkg::*;
#(
    parameter int OUT_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 div_run,
    input  logic [SLOTS*BPC-1:0] px_red_in,
    input  logic [SLOTS*BPC-1:0] px_grn_in,
    input  logic [SLOTS*BPC-1:0] px_blu_in,
    input  logic                 blank_in,
    input  logic                 hsync_in,
    input  logic                 vsync_in,
    input  logic                 csync_in,
    input  logic                 field_in,
    output logic                 load_out,
    output logic [BPC-1:0]       pix_red,
    output logic [BPC-1:0]       pix_grn,
    output logic [BPC-1:0]       pix_blu,
    output logic                 pix_first,
    output logic                 blank_out,
    output logic                 hsync_out,
    output logic                 vsync_out,
    output logic                 csync_out,
    output logic                 field_out
);

    phase_t phase_q;
    phase_t phase_nxt;
    vctl_t  ctl_in;
    word_t  hold_q;
    emit_t  emit;

    assign ctl_in = '{blank: blank_in, hsync: hsync_in, vsync: vsync_in,
                      csync: csync_in, field: field_in};

    pxm_phase_gen u_phase (
        .clk       (clk),
        .rst       (rst),
        .run       (div_run),
        .phase_q   (phase_q),
        .phase_nxt (phase_nxt),
        .load_out  (load_out)
    );

    pxm_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .run     (div_run),
        .phase_q (phase_q),
        .red_in  (px_red_in),
        .grn_in  (px_grn_in),
        .blu_in  (px_blu_in),
        .ctl_in  (ctl_in),
        .hold_q  (hold_q)
    );

    pxm_emit #(.OUT_STAGES(OUT_STAGES)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .run       (div_run),
        .phase_q   (phase_q),
        .phase_nxt (phase_nxt),
        .hold_q    (hold_q),
        .out       (emit)
    );

    assign pix_red   = emit.px.r;
    assign pix_grn   = emit.px.g;
    assign pix_blu   = emit.px.b;
    assign pix_first = emit.first;
    assign blank_out = emit.ctl.blank;
    assign hsync_out = emit.ctl.hsync;
    assign vsync_out = emit.ctl.vsync;
    assign csync_out = emit.ctl.csync;
    assign field_out = emit.ctl.field;

endmodule

// File: tb/pixport_serializer_tb.sv
module pixport_serializer_tb;

    localparam int NS   = 8;
    localparam int W    = 8;
    localparam int OSTG = 2;
    localparam int LAT  = NS / 2 + OSTG - 1;

    typedef struct packed {
        logic        first;
        logic [4:0]  ctl;
        logic [23:0] rgb;
    } rec_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst = 1'b1;
    logic            div_run = 1'b0;
    logic [NS*W-1:0] px_red_in = '0, px_grn_in = '0, px_blu_in = '0;
    logic            blank_in = 0, hsync_in = 0, vsync_in = 0, csync_in = 0, field_in = 0;
    logic            load_out, pix_first;
    logic [W-1:0]    pix_red, pix_grn, pix_blu;
    logic            blank_out, hsync_out, vsync_out, csync_out, field_out;

    pixport_serializer #(.OUT_STAGES(OSTG)) u_dut (
        .clk(clk), .rst(rst), .div_run(div_run),
        .px_red_in(px_red_in), .px_grn_in(px_grn_in), .px_blu_in(px_blu_in),
        .blank_in(blank_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .csync_in(csync_in), .field_in(field_in),
        .load_out(load_out), .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu),
        .pix_first(pix_first), .blank_out(blank_out), .hsync_out(hsync_out),
        .vsync_out(vsync_out), .csync_out(csync_out), .field_out(field_out)
    );

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    int   ph      = NS - 1;
    logic exp_lo  = 1'b0;
    bit   done    = 1'b0;
    bit   scramble = 1'b1;
    rec_t exp_tab [int];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    // input scrambler: values off the capture edge must be ignored (R6)
    always @(negedge clk) begin
        if (scramble) begin
            px_red_in <= {$urandom, $urandom};
            px_grn_in <= {$urandom, $urandom};
            px_blu_in <= {$urandom, $urandom};
            blank_in  <= ($urandom % 4) == 0;
            {hsync_in, vsync_in, csync_in, field_in} <= 4'($urandom);
        end
    end

    // behavioural schedule of expected outputs
    always @(posedge clk) begin : model
        bit run;
        run = !rst && div_run;
        cyc++;
        if (!run) begin
            ph = NS - 1;
            exp_lo = 1'b0;
            for (int k = cyc; k < cyc + LAT + NS + 2; k++)
                if (exp_tab.exists(k)) exp_tab.delete(k);
        end else begin
            if (ph == NS / 2 - 1) begin
                for (int k = 0; k < NS; k++) begin
                    rec_t r;
                    r.first = (k == 0);
                    r.ctl   = {blank_in, hsync_in, vsync_in, csync_in, field_in};
                    r.rgb   = blank_in ? 24'h0 :
                              {px_red_in[k*W +: W], px_grn_in[k*W +: W], px_blu_in[k*W +: W]};
                    exp_tab[cyc + LAT + k] = r;
                end
            end
            ph = (ph + 1) % NS;
            exp_lo = (ph < NS / 2);
        end
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (!done) begin
            rec_t  e;
            string tg;
            e  = exp_tab.exists(cyc) ? exp_tab[cyc] : '0;
            tg = e.ctl[4] ? "R8 colour" : (exp_tab.exists(cyc) ? "R3 colour" : "R2 colour");
            chk("R5 load_out", 64'(load_out), 64'(exp_lo));
            chk(tg, 64'({pix_red, pix_grn, pix_blu}), 64'(e.rgb));
            chk("R7 control", 64'({blank_out, hsync_out, vsync_out, csync_out, field_out}), 64'(e.ctl));
            chk("R4 first", 64'(pix_first), 64'(e.first));
        end
    end

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hold_for(int n);
        @(negedge clk);
        div_run = 1'b0;
        wait_neg(n);
        chk("R2 held outputs", 64'({load_out, pix_first, pix_red, pix_grn, pix_blu, hsync_out}), 64'h0);
    endtask

    task automatic release_measure();
        int cnt;
        @(negedge clk);
        div_run = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!pix_first && cnt < 40);
        chk("R4 release latency", 64'(cnt), 64'(NS / 2 + 1 + LAT));
    endtask

    task automatic directed_word(bit blk);
        logic [NS*W-1:0] wr, wg, wb;
        logic            prev;
        int              cnt;
        wr = {$urandom, $urandom} | 64'h0101010101010101;
        wg = {$urandom, $urandom};
        wb = {$urandom, $urandom};
        prev = 1'b1;
        @(negedge clk);
        while (!(load_out && !prev)) begin
            prev = load_out;
            @(negedge clk);
        end
        wait_neg(3);
        scramble = 1'b0;
        px_red_in = wr; px_grn_in = wg; px_blu_in = wb;
        blank_in = blk; hsync_in = 1'b1; vsync_in = 1'b0; csync_in = 1'b1; field_in = 1'b1;
        @(negedge clk);
        px_red_in = ~wr; px_grn_in = ~wg; px_blu_in = ~wb;
        blank_in = ~blk; hsync_in = 1'b0; csync_in = 1'b0;
        scramble = 1'b1;
        cnt = 0;
        while (!pix_first && cnt < 12) begin
            @(negedge clk);
            cnt++;
        end
        chk("R6 capture edge latency", 64'(cnt), 64'(LAT));
        for (int k = 0; k < NS; k++) begin
            if (blk) begin
                chk("R8 blanked colour", 64'({pix_red, pix_grn, pix_blu}), 64'h0);
                chk("R8 sync passes", 64'({hsync_out, csync_out, field_out}), 64'h7);
            end else begin
                chk("R6 red slot", 64'(pix_red), 64'(wr[k*W +: W]));
                chk("R3 blue slot", 64'(pix_blu), 64'(wb[k*W +: W]));
                chk("R7 hsync held", 64'(hsync_out), 64'h1);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        wait_neg(4);
        chk("R1 reset outputs", 64'({load_out, pix_first, pix_red, pix_grn, pix_blu}), 64'h0);
        chk("R1 reset control", 64'({blank_out, hsync_out, vsync_out, csync_out, field_out}), 64'h0);
        @(negedge clk);
        rst = 1'b0;
        wait_neg(3);
        chk("R2 held after reset", 64'({load_out, pix_first, pix_red}), 64'h0);
        release_measure();
        wait_neg(200);
        for (int i = 0; i < 8; i++) begin
            wait_neg(37 + i * 3);
            hold_for(1 + i);
            release_measure();
        end
        wait_neg(30);
        directed_word(1'b0);
        directed_word(1'b1);
        directed_word(1'b0);
        wait_neg(50);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R4 watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule